// File: doc/BRIEF.md
# ADC Result Store with Format Windows

This block keeps the conversion results of an analog-to-digital converter sequencer. It has 64 entries of 10 bits each. When a conversion finishes, the converter writes its result into the entry whose index matches the command slot that asked for it. Software reaches the same entries over a 16-bit register bus. It reads results back and can use unused entries as scratch storage.

The array exists once, but the bus sees it through three consecutive aliased windows of 128 bytes each. Each window formats the stored value differently on the way out: right-justified, left-justified with the top bit inverted (offset binary turned into two's complement), or left-justified unsigned. A fourth window reads as zero. Every bus write is taken as right-justified, whichever window it goes to. Bus reads are registered: the data arrives one cycle later with a valid strobe.

Top module: `adc_result_store`

## Requirements
- R1: While reset is asserted and after it is released, every entry holds zero, `bus_rvalid` is 0 and `bus_rdata` is 0.
- R2: When `cv_wr_en` is high at a clock edge, `cv_wr_data` is stored in entry `cv_wr_idx`.
- R3: A bus read (`bus_sel`=1, `bus_wr`=0) raises `bus_rvalid` for exactly one cycle, on the edge that follows. `bus_rdata` is zero whenever `bus_rvalid` is low.
- R4: Address bits [6:1] select the entry and bit 0 is ignored. Window 0 (address bits [8:7]=0) returns the 10 bits in [9:0], with [15:10] zero.
- R5: Window 2 (bits [8:7]=2) returns the 10 bits in [15:6], with [5:0] zero.
- R6: Window 1 (bits [8:7]=1) returns the 10 bits in [15:6] with bit 15 inverted, and [5:0] zero.
- R7: Window 3 (bits [8:7]=3) reads as zero and ignores writes.
- R8: A bus write (`bus_sel`=1, `bus_wr`=1) to window 0, 1 or 2 stores `bus_wdata[9:0]` right-justified in the addressed entry. Bits [15:10] are ignored.
- R9: If the converter and the bus write the same entry in one cycle, the converter value is stored. When they write different entries, both writes happen.
- R10: A read returns the value held before the edge at which it is sampled. A same-cycle converter write to that entry shows up only in later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cv_wr_en | input | 1 | Converter result write strobe |
| cv_wr_idx | input | 6 | Command slot index of the result |
| cv_wr_data | input | 10 | Conversion result |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address: [8:7] window, [6:1] entry |
| bus_wdata | input | 16 | Bus write data (right-justified) |
| bus_rdata | output | 16 | Formatted read data, zero when not valid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |

## Verification
The bench drives writes of the extreme codes 0x000, 0x3FF, 0x200 and 0x1FF, then reads each one through every window. A swapped window decode, or a sign inversion on the wrong bit, shows up as a mismatch on those codes. It writes through window 3 and with the upper data bits set. A block that let either write land would change a later right-justified read. The bench also makes the converter and the bus collide on one entry, and lines up a read with a converter write. A wrong priority stores the bus value, and a read that bypasses the array returns the new value one cycle too early. A long random mix is compared against a behavioural model on every clock.

// File: rtl/adcres_pkg.sv
package adcres_pkg;
  typedef enum logic [1:0] {
    WIN_RIGHT = 2'd0,
    WIN_LSIGN = 2'd1,
    WIN_LUNS  = 2'd2,
    WIN_NONE  = 2'd3
  } win_e;
endpackage

// File: rtl/adcres_decode.sv
module adcres_decode
  import adcres_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int ADDR_W = IDX_W + 3
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              rd_req,
  output logic              wr_req,
  output logic [IDX_W-1:0]  idx,
  output win_e              win
);
  always_comb begin
    idx    = bus_addr[IDX_W:1];
    win    = win_e'(bus_addr[IDX_W+2:IDX_W+1]);
    rd_req = bus_sel && !bus_wr;
    wr_req = bus_sel && bus_wr && (win != WIN_NONE);
  end
endmodule

// File: rtl/adcres_store.sv
module adcres_store #(
  parameter int IDX_W = 6,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cv_en,
  input  logic [IDX_W-1:0] cv_idx,
  input  logic [RES_W-1:0] cv_data,
  input  logic             bw_en,
  input  logic [IDX_W-1:0] bw_idx,
  input  logic [RES_W-1:0] bw_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [RES_W-1:0] rd_data
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [RES_W-1:0] mem_q   [ENTRIES];
  logic [RES_W-1:0] mem_d   [ENTRIES];
  logic [ENTRIES-1:0] we;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic cv_hit, bw_hit;
    assign cv_hit   = cv_en && (cv_idx == IDX_W'(e));
    assign bw_hit   = bw_en && (bw_idx == IDX_W'(e));
    assign we[e]    = cv_hit || bw_hit;
    // converter side wins a same-entry collision
    assign mem_d[e] = cv_hit ? cv_data : bw_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) mem_q[e] <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++)
        if (we[e]) mem_q[e] <= mem_d[e];
    end
  end

  assign rd_data = mem_q[rd_idx];

  // R2
  cv_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cv_en |=> mem_q[$past(cv_idx)] == $past(cv_data));

  // R9
  bw_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_en && !(cv_en && cv_idx == bw_idx)) |=> mem_q[$past(bw_idx)] == $past(bw_data));
endmodule

// File: rtl/adcres_format.sv
module adcres_format
  import adcres_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int BUS_W = 16
) (
  input  logic [RES_W-1:0] raw,
  input  win_e             win,
  output logic [BUS_W-1:0] word
);
  localparam int PAD = BUS_W - RES_W;

  always_comb begin
    unique case (win)
      WIN_RIGHT: word = {{PAD{1'b0}}, raw};
      WIN_LSIGN: word = {~raw[RES_W-1], raw[RES_W-2:0], {PAD{1'b0}}};
      WIN_LUNS:  word = {raw, {PAD{1'b0}}};
      default:   word = '0;
    endcase
  end
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store
  import adcres_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int RES_W = 10,
  parameter int BUS_W = 16,
  localparam int ADDR_W = IDX_W + 3,
  localparam int PAD    = BUS_W - RES_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cv_wr_en,
  input  logic [IDX_W-1:0]  cv_wr_idx,
  input  logic [RES_W-1:0]  cv_wr_data,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid
);
  logic             rd_req, wr_req;
  logic [IDX_W-1:0] dec_idx;
  win_e             dec_win;
  logic [RES_W-1:0] raw;
  logic [BUS_W-1:0] fmt_word;
  logic [BUS_W-1:0] rdata_d, rdata_q;
  logic             rvalid_d, rvalid_q;

  adcres_decode #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .rd_req  (rd_req),
    .wr_req  (wr_req),
    .idx     (dec_idx),
    .win     (dec_win)
  );

  adcres_store #(.IDX_W(IDX_W), .RES_W(RES_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .cv_en  (cv_wr_en),
    .cv_idx (cv_wr_idx),
    .cv_data(cv_wr_data),
    .bw_en  (wr_req),
    .bw_idx (dec_idx),
    .bw_data(bus_wdata[RES_W-1:0]),
    .rd_idx (dec_idx),
    .rd_data(raw)
  );

  adcres_format #(.RES_W(RES_W), .BUS_W(BUS_W)) u_fmt (
    .raw (raw),
    .win (dec_win),
    .word(fmt_word)
  );

  always_comb begin
    rvalid_d = rd_req;
    rdata_d  = rd_req ? fmt_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rdata_q;

  // R3
  rvalid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  // R3
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> !bus_rvalid);

  // R3
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rvalid |-> bus_rdata == '0);

  // R4
  right_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[ADDR_W-1:ADDR_W-2] == 2'd0)
      |=> bus_rdata[BUS_W-1:RES_W] == '0);

  // R5
  left_lower_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[ADDR_W-2] != bus_addr[ADDR_W-1])
      |=> bus_rdata[PAD-1:0] == '0);

  // R7
  hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[ADDR_W-1:ADDR_W-2] == 2'd3)
      |=> bus_rdata == '0);
endmodule

// File: tb/adc_result_store_test.sv
module adc_result_store_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cv_wr_en = 1'b0;
  logic [5:0]  cv_wr_idx = '0;
  logic [9:0]  cv_wr_data = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;

  int checks = 0;
  int errors = 0;
  int model [64];

  always #10 clk = ~clk;

  adc_result_store uut (
    .clk(clk), .rst_n(rst_n),
    .cv_wr_en(cv_wr_en), .cv_wr_idx(cv_wr_idx), .cv_wr_data(cv_wr_data),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  function automatic int fmt(int v, int w);
    case (w)
      0: return v;
      1: return ((v ^ 512) << 6) & 16'hFFFF;
      2: return (v << 6) & 16'hFFFF;
      default: return 0;
    endcase
  endfunction

  function automatic int mk_addr(int w, int idx, int b0);
    return (w << 7) | (idx << 1) | b0;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit cen, int cidx, int cdat, bit sel, bit wr, int addr, int wd, string tag);
    int idx, w, exp_v, exp_d;
    cv_wr_en = cen; cv_wr_idx = cidx[5:0]; cv_wr_data = cdat[9:0];
    bus_sel = sel; bus_wr = wr; bus_addr = addr[8:0]; bus_wdata = wd[15:0];
    @(posedge clk);
    idx = (addr >> 1) & 63;
    w = (addr >> 7) & 3;
    exp_v = (sel && !wr) ? 1 : 0;
    exp_d = exp_v ? fmt(model[idx], w) : 0;
    if (sel && wr && w != 3) model[idx] = wd & 10'h3FF;
    if (cen) model[cidx] = cdat & 10'h3FF;
    @(negedge clk);
    check(tag, bus_rvalid, exp_v, "rvalid");
    check(tag, bus_rdata, exp_d, "rdata");
  endtask

  task automatic rd(int w, int idx, string tag);
    cyc(0, 0, 0, 1, 0, mk_addr(w, idx, 0), 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int vals [4] = '{0, 10'h3FF, 10'h200, 10'h1FF};
    for (int i = 0; i < 64; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    check("R1", bus_rvalid, 0, "rvalid in reset");
    check("R1", bus_rdata, 0, "rdata in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", bus_rvalid, 0, "rvalid after reset");
    for (int i = 0; i < 64; i++) rd(0, i, "R1");

    // converter writes of extreme codes, read in every window
    for (int i = 0; i < 4; i++) cyc(1, 10 + i, vals[i], 0, 0, 0, 0, "R2");
    for (int i = 0; i < 4; i++) begin
      rd(0, 10 + i, "R4");
      rd(1, 10 + i, "R6");
      rd(2, 10 + i, "R5");
      rd(3, 10 + i, "R7");
    end
    cyc(0, 0, 0, 1, 0, mk_addr(0, 11, 1), 0, "R4");   // bit 0 ignored
    cyc(0, 0, 0, 0, 0, 0, 0, "R3");                    // idle after read

    // bus writes through each window with upper bits set
    cyc(0, 0, 0, 1, 1, mk_addr(0, 20, 0), 16'hFC55, "R8");
    cyc(0, 0, 0, 1, 1, mk_addr(1, 21, 1), 16'hA2AA, "R8");
    cyc(0, 0, 0, 1, 1, mk_addr(2, 22, 0), 16'h0301, "R8");
    rd(0, 20, "R8"); rd(0, 21, "R8"); rd(2, 22, "R8");

    // window 3 write ignored
    cyc(0, 0, 0, 1, 1, mk_addr(3, 20, 0), 16'h0123, "R7");
    rd(0, 20, "R7");

    // collisions
    cyc(1, 30, 10'h2AB, 1, 1, mk_addr(0, 30, 0), 16'h0111, "R9");
    rd(0, 30, "R9");
    cyc(1, 31, 10'h0F0, 1, 1, mk_addr(0, 32, 0), 16'h0222, "R9");
    rd(0, 31, "R9"); rd(0, 32, "R9");

    // read alongside converter write to same entry
    cyc(1, 12, 10'h155, 1, 0, mk_addr(0, 12, 0), 0, "R10");
    rd(0, 12, "R10");

    // back-to-back reads then idle
    rd(1, 31, "R3"); rd(2, 31, "R3");
    cyc(0, 0, 0, 0, 1, mk_addr(0, 31, 0), 16'hFFFF, "R3"); // no select: no write
    rd(0, 31, "R3");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom;
      cyc(r[0], $urandom_range(0, 63), $urandom_range(0, 1023),
          r[1], r[2], $urandom_range(0, 511), $urandom_range(0, 65535), "R9");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule